// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers sixteen interrupt sources into one active-low request line for a processor on a 68000-style bus. Eight sources are general-purpose input lines, each watched for a rising or a falling edge. The other eight are single-cycle event strobes from neighbouring peripherals. Each channel has an enable bit that gates whether an event may set its pending bit, and a mask bit that decides whether a pending bit reaches the request line. The registers are reached through a synchronous select/write port. Each 16-bit set is split into a high half (channels 15..8) and a low half (channels 7..0).

When the processor acknowledges, the block serves the highest-numbered pending unmasked channel. It clears that pending bit and returns a vector byte on the low data byte. It may answer only while its chain-enable input is asserted, which means no upstream device is asking for service. It passes the chain on to lower-priority devices only while it has nothing to serve itself.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Registers sit at these addresses: 0 line data, 1 edge select, 2 line direction, 3 enable high, 4 enable low, 5 pending high, 6 pending low, 7 mask high, 8 mask low, 9 vector base. A read with `sel`=1 and `wrEn`=0 puts the value on `dataOut` after the next clock edge, and `dataOut` holds it until the next read or acknowledge. The vector base reads back as its upper nibble with bits 3..0 as zero. Address 0 reads the output latch on lines whose direction bit is 1 and the pin on lines whose direction bit is 0. Addresses 10 to 15 read as 0 and ignore writes.
- R2: While `rstN` is low, every register, `dataOut` and `vecStrobe` are zero. As a result `irqN` is 1, `gpDir` is 0 (all lines are inputs) and `enOutN` follows `enInN`.
- R3: `irqN` is 0 exactly while some channel is both pending and masked-in. Clearing the pending bit or the mask bit negates `irqN` after that write's clock edge.
- R4: Line i drives channel i (0..7). With edge-select bit i at 1 it reacts to a 0-to-1 change of `gpIn[i]` between two clock edges, and with the bit at 0 it reacts to a 1-to-0 change. `periphEvt[j]` high at a clock edge is an event on channel 8+j.
- R5: An event sets a pending bit only while that channel's enable bit is 1. Clearing an enable bit leaves an already pending bit set.
- R6: A write of 0 to a pending bit clears it, and a write of 1 leaves it unchanged. An event in the same cycle as a clear (by write or by acknowledge) leaves the bit set.
- R7: An acknowledge is `ackN`=0 at a clock edge while `enInN`=0 and a request is active. It clears the pending bit of the highest-numbered pending masked-in channel. On the following cycle `vecStrobe` is 1 for one cycle and `dataOut` = {vector base bits 7..4, channel number}.
- R8: With `ackN`=0 while `enInN`=1 or while no request is active, no pending bit changes, `vecStrobe` stays 0 and `dataOut` keeps its value.
- R9: `enOutN` is 0 only while `enInN` is 0 and no request is active.
- R10: `sel` and `ackN`=0 are never asserted together. This is a protocol rule on the driver.
- R11: `gpOut` equals the line data register and `gpDir` equals the direction register (1 = output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register access strobe |
| wrEn | input | 1 | 1 = write, 0 = read, when `sel` is 1 |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| dataOut | output | 8 | Read data or vector byte |
| vecStrobe | output | 1 | High for one cycle when `dataOut` carries a vector |
| ackN | input | 1 | Interrupt acknowledge, active low |
| enInN | input | 1 | Chain enable from upstream, active low |
| enOutN | output | 1 | Chain enable to downstream, active low |
| irqN | output | 1 | Interrupt request, active low |
| gpIn | input | 8 | General-purpose line pins |
| gpOut | output | 8 | General-purpose output values |
| gpDir | output | 8 | General-purpose direction, 1 = drive |
| periphEvt | input | 8 | Event strobes for channels 15..8 |

## Verification
The bench looks for acknowledge priority errors. It makes two channels pending in different halves, and a design that served the lowest channel or either half first would return the wrong vector nibble. It acknowledges while the upstream chain is busy, where a design that ignored `enInN` would clear a pending bit and strobe a vector. It lands a fresh event on the channel being acknowledged, where a design that ordered clear after set would lose that event. It also triggers edges on a disabled channel, where a leaky enable would raise `irqN`. A long mixed random run is compared against the reference model on every cycle.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int GP_N     = 8;
  localparam int CH_N     = 2 * GP_N;
  localparam int HALF_W   = CH_N / 2;
  localparam int CHAN_W   = $clog2(CH_N);
  localparam int NUM_REGS = 10;

  typedef enum logic [ADDR_W-1:0] {
    REG_LINE    = 4'd0,
    REG_EDGE    = 4'd1,
    REG_DIR     = 4'd2,
    REG_EN_HI   = 4'd3,
    REG_EN_LO   = 4'd4,
    REG_PEND_HI = 4'd5,
    REG_PEND_LO = 4'd6,
    REG_MASK_HI = 4'd7,
    REG_MASK_LO = 4'd8,
    REG_VEC     = 4'd9
  } regAddrE;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrHit;
    logic                rdHit;
    logic [ADDR_W-1:0]   rdAddr;
    logic                ackTake;
    logic [CHAN_W-1:0]   ackChan;
  } ctrlStrobesT;
endpackage

// File: rtl/ivc_control.sv
module ivc_control
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ackN,
  input  logic              enInN,
  input  logic [CH_N-1:0]   activeVec,
  output ctrlStrobesT       strobes
);
  logic [NUM_REGS-1:0] wrHitV;
  logic [CHAN_W-1:0]   winner;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
    assign wrHitV[k] = sel && wrEn && (addr == ADDR_W'(k));
  end

  // Ascending scan: the last hit, the highest channel, wins
  always_comb begin
    winner = '0;
    for (int i = 0; i < CH_N; i++) begin
      if (activeVec[i]) winner = CHAN_W'(i);
    end
  end

  always_comb begin
    strobes.wrHit   = wrHitV;
    strobes.rdHit   = sel && !wrEn;
    strobes.rdAddr  = addr;
    strobes.ackTake = !ackN && !enInN && (|activeVec);
    strobes.ackChan = winner;
  end

  AST_NO_SEL_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !(sel && !ackN)); // R10
  AST_ACK_SERVES_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackTake |-> activeVec[strobes.ackChan]); // R7
  AST_ACK_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackTake |-> ((activeVec >> strobes.ackChan) == CH_N'(1))); // R7
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [GP_N-1:0]   gpIn,
  input  logic [GP_N-1:0]   periphEvt,
  output logic [CH_N-1:0]   activeVec,
  output logic [DATA_W-1:0] dataOut,
  output logic              vecStrobe,
  output logic [GP_N-1:0]   gpOut,
  output logic [GP_N-1:0]   gpDir
);
  localparam int NIB_W = DATA_W - CHAN_W;

  logic [CH_N-1:0]   pendQ, maskQ, enQ;
  logic [CH_N-1:0]   pendKeep, maskNext, enNext, pendNext, ackClr, evtVec;
  logic [GP_N-1:0]   edgeQ, prevQ, evtGp;
  logic [NIB_W-1:0]  vecBaseQ;
  logic [DATA_W-1:0] rdValue;

  // Edge detect on the general lines, picked per line by edgeQ
  assign evtGp  = (edgeQ & gpIn & ~prevQ) | (~edgeQ & ~gpIn & prevQ);
  assign evtVec = {periphEvt, evtGp};

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int LO     = h * HALF_W;
    localparam int EN_IX  = (h == 1) ? int'(REG_EN_HI)   : int'(REG_EN_LO);
    localparam int MSK_IX = (h == 1) ? int'(REG_MASK_HI) : int'(REG_MASK_LO);
    localparam int PND_IX = (h == 1) ? int'(REG_PEND_HI) : int'(REG_PEND_LO);
    assign enNext[LO+:HALF_W]   = strobes.wrHit[EN_IX]  ? wrData : enQ[LO+:HALF_W];
    assign maskNext[LO+:HALF_W] = strobes.wrHit[MSK_IX] ? wrData : maskQ[LO+:HALF_W];
    assign pendKeep[LO+:HALF_W] = strobes.wrHit[PND_IX] ? (pendQ[LO+:HALF_W] & wrData)
                                                        : pendQ[LO+:HALF_W];
  end

  assign ackClr    = strobes.ackTake ? (CH_N'(1) << strobes.ackChan) : '0;
  assign pendNext  = (pendKeep & ~ackClr) | (evtVec & enQ);
  assign activeVec = pendQ & maskQ;

  always_comb begin
    case (strobes.rdAddr)
      REG_LINE:    rdValue = (gpOut & gpDir) | (gpIn & ~gpDir);
      REG_EDGE:    rdValue = edgeQ;
      REG_DIR:     rdValue = gpDir;
      REG_EN_HI:   rdValue = enQ[CH_N-1:HALF_W];
      REG_EN_LO:   rdValue = enQ[HALF_W-1:0];
      REG_PEND_HI: rdValue = pendQ[CH_N-1:HALF_W];
      REG_PEND_LO: rdValue = pendQ[HALF_W-1:0];
      REG_MASK_HI: rdValue = maskQ[CH_N-1:HALF_W];
      REG_MASK_LO: rdValue = maskQ[HALF_W-1:0];
      REG_VEC:     rdValue = {vecBaseQ, {CHAN_W{1'b0}}};
      default:     rdValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ     <= '0;
      maskQ     <= '0;
      enQ       <= '0;
      edgeQ     <= '0;
      prevQ     <= '0;
      gpOut     <= '0;
      gpDir     <= '0;
      vecBaseQ  <= '0;
      dataOut   <= '0;
      vecStrobe <= 1'b0;
    end else begin
      pendQ     <= pendNext;
      maskQ     <= maskNext;
      enQ       <= enNext;
      prevQ     <= gpIn;
      vecStrobe <= strobes.ackTake;
      if (strobes.wrHit[REG_EDGE]) edgeQ    <= wrData;
      if (strobes.wrHit[REG_DIR])  gpDir    <= wrData;
      if (strobes.wrHit[REG_LINE]) gpOut    <= wrData;
      if (strobes.wrHit[REG_VEC])  vecBaseQ <= wrData[DATA_W-1:CHAN_W];
      if (strobes.ackTake)         dataOut  <= {vecBaseQ, strobes.ackChan};
      else if (strobes.rdHit)      dataOut  <= rdValue;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_chk
    AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendQ[c]) |-> $past(enQ[c])); // R5
  end

  AST_VECTOR_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackTake |=> (vecStrobe && dataOut[CHAN_W-1:0] == $past(strobes.ackChan))); // R7
  AST_NO_STRAY_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.ackTake) |-> !vecStrobe); // R8
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              vecStrobe,
  input  logic              ackN,
  input  logic              enInN,
  output logic              enOutN,
  output logic              irqN,
  input  logic [GP_N-1:0]   gpIn,
  output logic [GP_N-1:0]   gpOut,
  output logic [GP_N-1:0]   gpDir,
  input  logic [GP_N-1:0]   periphEvt
);
  ctrlStrobesT     strobes;
  logic [CH_N-1:0] activeVec;

  ivc_control u_control (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr),
    .ackN(ackN), .enInN(enInN), .activeVec(activeVec), .strobes(strobes)
  );

  ivc_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .gpIn(gpIn), .periphEvt(periphEvt), .activeVec(activeVec),
    .dataOut(dataOut), .vecStrobe(vecStrobe), .gpOut(gpOut), .gpDir(gpDir)
  );

  assign irqN   = ~(|activeVec);
  assign enOutN = enInN | (|activeVec);

  AST_CHAIN_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> enOutN); // R9
  AST_ACK_ONLY_WITH_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    vecStrobe |-> $past(!enInN && !irqN)); // R8
  AST_MASK_CLEAR_QUIETS: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrEn && addr == REG_MASK_HI && wrData == '0) ##1
    (sel && wrEn && addr == REG_MASK_LO && wrData == '0) |=> irqN); // R3
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sel = 1'b0, wrEn = 1'b0, ackN = 1'b1, enInN = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0, gpIn = '0, periphEvt = '0;
  logic [7:0] dataOut, gpOut, gpDir;
  logic       vecStrobe, enOutN, irqN;

  int nChecks = 0, nFails = 0, nViol = 0;
  bit compareOn = 1'b0;

  // reference model state
  logic [15:0] mPend, mMask, mEn;
  logic [7:0]  mEdge, mDir, mOut, mPrev, mRd;
  logic [3:0]  mVecHi;
  bit          mVs;

  always #5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .dataOut(dataOut), .vecStrobe(vecStrobe), .ackN(ackN), .enInN(enInN),
    .enOutN(enOutN), .irqN(irqN), .gpIn(gpIn), .gpOut(gpOut), .gpDir(gpDir),
    .periphEvt(periphEvt)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    logic [15:0] act, np, evs;
    logic [7:0]  rv;
    int          w;
    bit          take;
    if (sel && !ackN) nViol++;
    if (!rstN) begin
      mPend = '0; mMask = '0; mEn = '0; mEdge = '0; mDir = '0; mOut = '0;
      mPrev = '0; mRd = '0; mVecHi = '0; mVs = 0;
    end else begin
      act  = mPend & mMask;
      take = !ackN && !enInN && (act != 0);
      w = -1;
      for (int i = 15; i >= 0; i--) if (act[i] && w < 0) w = i;
      for (int i = 0; i < 8; i++)
        evs[i] = mEdge[i] ? (gpIn[i] && !mPrev[i]) : (!gpIn[i] && mPrev[i]);
      evs[15:8] = periphEvt;
      np = mPend;
      if (sel && wrEn && addr == 5) np[15:8] &= wrData;
      if (sel && wrEn && addr == 6) np[7:0] &= wrData;
      if (take) np[w] = 1'b0;
      np |= evs & mEn;
      case (addr)
        0: rv = (mOut & mDir) | (gpIn & ~mDir);
        1: rv = mEdge;   2: rv = mDir;
        3: rv = mEn[15:8];   4: rv = mEn[7:0];
        5: rv = mPend[15:8]; 6: rv = mPend[7:0];
        7: rv = mMask[15:8]; 8: rv = mMask[7:0];
        9: rv = {mVecHi, 4'h0};
        default: rv = 8'h00;
      endcase
      mVs = take;
      if (take) mRd = {mVecHi, 4'(w)};
      else if (sel && !wrEn) mRd = rv;
      if (sel && wrEn) begin
        case (addr)
          0: mOut = wrData;  1: mEdge = wrData;  2: mDir = wrData;
          3: mEn[15:8] = wrData;   4: mEn[7:0] = wrData;
          7: mMask[15:8] = wrData; 8: mMask[7:0] = wrData;
          9: mVecHi = wrData[7:4];
          default: ;
        endcase
      end
      mPend = np;
      mPrev = gpIn;
    end
  end

  // Per-cycle comparison, before inputs move at negedge+1
  always @(negedge clk) begin
    if (rstN && compareOn) begin
      chk("R3 irqN", irqN, ((mPend & mMask) == 0));
      chk("R9 enOutN", enOutN, (enInN || ((mPend & mMask) != 0)));
      chk("R7 vecStrobe", vecStrobe, mVs);
      chk(mVs ? "R7 dataOut vector" : "R1 dataOut", dataOut, mRd);
      chk("R11 gpOut", gpOut, mOut);
      chk("R11 gpDir", gpDir, mDir);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    sel = 1; wrEn = 1; addr = a; wrData = d; tick();
    sel = 0; wrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    sel = 1; wrEn = 0; addr = a; tick();
    sel = 0; v = dataOut;
  endtask

  task automatic ack();
    ackN = 0; tick(); ackN = 1;
  endtask

  initial begin : watchdog
    #2000000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [7:0] v;
    tick(); tick();
    chk("R2 irqN in reset", irqN, 1);
    chk("R2 gpDir in reset", gpDir, 0);
    chk("R2 enOutN follows enInN", enOutN, 0);
    rstN = 1; compareOn = 1; tick();
    rd(6, v); chk("R2 pending low after reset", v, 8'h00);
    rd(9, v); chk("R2 vector base after reset", v, 8'h00);

    wr(9, 8'hA7); rd(9, v); chk("R1 vector base readback", v, 8'hA0);
    wr(1, 8'h01); rd(1, v); chk("R1 edge select readback", v, 8'h01);
    rd(12, v); chk("R1 unmapped read", v, 8'h00);
    wr(11, 8'hFF); rd(7, v); chk("R1 unmapped write ignored", v, 8'h00);
    wr(3, 8'hFF); wr(4, 8'hFB); wr(7, 8'hFF); wr(8, 8'hFF);

    // R4 rising edge on line 0
    gpIn = 8'h01; tick();
    chk("R4 rising edge raises irq", irqN, 0);
    // R4 falling edge on line 1 (select bit 0)
    gpIn = 8'h03; tick(); gpIn = 8'h01; tick();
    rd(6, v); chk("R4 both line edges pending", v, 8'h03);
    // R3 clearing masks quiets
    wr(7, 8'h00); wr(8, 8'h00);
    chk("R3 mask clear negates", irqN, 1);
    wr(8, 8'hFF); wr(7, 8'hFF);
    chk("R3 mask restore asserts", irqN, 0);
    // R6 pending write
    wr(6, 8'hFE); rd(6, v); chk("R6 write0 clears write1 keeps", v, 8'h02);
    // R5 disabled channel 2
    gpIn = 8'h05; tick(); gpIn = 8'h01; tick();
    rd(6, v); chk("R5 disabled channel stays clear", v, 8'h02);
    wr(4, 8'h00); rd(6, v); chk("R5 disable keeps pending", v, 8'h02);
    wr(4, 8'hFF);

    // R7 priority: ch15 and ch1
    periphEvt = 8'h80; tick(); periphEvt = 8'h00;
    // R8 ack while upstream busy
    enInN = 1; ack();
    chk("R8 no vector when chain busy", vecStrobe, 0);
    chk("R9 enOutN high upstream busy", enOutN, 1);
    rd(5, v); chk("R8 pending untouched", v, 8'h80);
    enInN = 0;
    chk("R9 enOutN blocked by own request", enOutN, 1);
    ack();
    chk("R7 vector strobe", vecStrobe, 1);
    chk("R7 highest channel vector", dataOut, 8'hAF);
    chk("R7 irq stays for remaining", irqN, 0);
    ack();
    chk("R7 second vector", dataOut, 8'hA1);
    chk("R7 irq released", irqN, 1);
    chk("R9 chain passed on", enOutN, 0);
    ack();
    chk("R8 no vector when idle", vecStrobe, 0);
    chk("R8 dataOut held", dataOut, 8'hA1);

    // R6 event on the channel being acknowledged
    periphEvt = 8'h80; tick();
    ackN = 0; tick(); ackN = 1; periphEvt = 8'h00;
    chk("R6 vector during collision", dataOut, 8'hAF);
    rd(5, v); chk("R6 event wins over ack clear", v, 8'h80);
    wr(5, 8'h00);

    // R11 and R1 line port
    wr(2, 8'h0F); wr(0, 8'hA5); gpIn = 8'h30; tick();
    chk("R11 gpOut", gpOut, 8'hA5);
    chk("R11 gpDir", gpDir, 8'h0F);
    rd(0, v); chk("R1 line read mixes latch and pins", v, 8'h35);
    wr(6, 8'h00); wr(5, 8'h00);

    // random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 100;
      sel = 0; wrEn = 0; ackN = 1;
      if (r < 30) begin
        sel = 1; wrEn = ($urandom % 2); addr = 4'($urandom % 12); wrData = 8'($urandom);
      end else if (r < 45) ackN = 0;
      enInN = (($urandom % 4) == 0);
      gpIn = gpIn ^ 8'($urandom & $urandom);
      periphEvt = 8'($urandom & $urandom & $urandom);
      tick();
    end
    sel = 0; ackN = 1; periphEvt = 0; tick();
    chk("R10 no select with acknowledge", nViol, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule